// File: doc/BRIEF.md
# Indirect Control-Transfer Unit

This unit resolves the indirect jumps and indirect calls of a simple in-order core. For each accepted operation it takes five inputs: a decoded 3-bit operation code, the current PC, one source register value, a short literal and the current stack pointer. From these it produces the next PC. Depending on the form, it also produces the fixed link-register value, or a pushed return address together with a lowered stack pointer. Two forms fetch their target from memory through a single-word read port. Calls push their return address through a single-word write port.

The call forms take a skip count in instructions. The pushed return address is then the current PC plus four times that count. Code placed directly after the call, such as a jump to the usual target, is executed only when the target was mispredicted and is stepped over on return. A memory-target operation holds `busy` for the one cycle in which the read answers. If that read faults, the unit raises an exception with the failing address. In that case it emits no next PC, no stack write and no stack-pointer update, so the call behaves as a transaction.

Top module: `ict_unit`

## Requirements
- R1: Operation code 0 (register jump) sets `npc` to `src_val`, with `npc_valid` high in the cycle after acceptance. It drives no link, stack or memory strobe.
- R2: Operation code 1 (table jump) sets `npc` to the zero-extended `lit_val` plus `src_val` shifted left by ENTRY_SHIFT (default 3, two instructions per entry). The result appears in the cycle after acceptance.
- R3: Operation code 2 (memory jump) raises `rd_req` in the accept cycle with `rd_addr` equal to `src_val` plus the zero-extended `lit_val`. The word returned on `rd_data` one cycle later becomes `npc`, with `npc_valid` high in the cycle after that response.
- R4: Operation code 3 (branch-and-link) sets `npc` to `src_val` and pulses `link_we` with `link_val` equal to `cur_pc` plus 4. It performs no memory write and no stack-pointer update.
- R5: Operation code 4 (register call with skip) sets `npc` to `src_val` and writes `cur_pc + 4*skip_cnt` to address `sp_in`. In the same cycle it pulses `sp_we` with `sp_out` equal to `sp_in - 4`.
- R6: Operation code 5 (memory call with skip) reads at `src_val + lit_val` and sets `npc` to the loaded word. In the same result cycle it performs the R5 push, using the PC, skip count and stack pointer sampled at acceptance.
- R7: A read answered with `rd_fault` high pulses `exc` with `exc_addr` equal to the read address. In that cycle it raises none of `npc_valid`, `wr_en` and `sp_we`.
- R8: `busy` is high only in the single cycle after a memory-form acceptance. An `op_valid` presented while `busy` is high is ignored.
- R9: Operation codes 6 and 7 pulse `illegal` in the cycle after acceptance and raise no other strobe.
- R10: During and right after reset, `npc_valid`, `link_we`, `wr_en`, `sp_we`, `exc`, `illegal` and `busy` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 3 | Form selector, codes 0..5 legal |
| cur_pc | input | 32 | Byte address of the transfer instruction |
| src_val | input | 32 | Source register value |
| lit_val | input | 16 | Literal table base or offset |
| skip_cnt | input | 6 | Instructions to step over on return |
| sp_in | input | 32 | Current stack pointer |
| busy | output | 1 | Waiting on a read response |
| rd_req | output | 1 | Memory read request |
| rd_addr | output | 32 | Memory read address |
| rd_data | input | 32 | Read word, one cycle after request |
| rd_fault | input | 1 | Read faulted, one cycle after request |
| npc_valid | output | 1 | Next PC strobe |
| npc | output | 32 | Next PC |
| link_we | output | 1 | Link register write strobe |
| link_val | output | 32 | Link register value |
| wr_en | output | 1 | Stack write strobe |
| wr_addr | output | 32 | Stack write address |
| wr_data | output | 32 | Pushed return address |
| sp_we | output | 1 | Stack pointer update strobe |
| sp_out | output | 32 | New stack pointer |
| exc | output | 1 | Target load fault |
| exc_addr | output | 32 | Faulting address |
| illegal | output | 1 | Unknown operation code |

## Verification
The assertions assume that memory answers every `rd_req` exactly one cycle later, with `rd_data` and `rd_fault` meaningful only in that response cycle. They also assume the operation inputs are stable in the accept cycle. The bench supplies a memory model that registers each request on the clock edge. It returns an address-derived word and faults any address whose top nibble is F. Operation inputs are changed only at falling edges, and a competing operation is deliberately presented during the busy cycle.

// File: rtl/ict_pkg.sv
`timescale 1ns/1ps
package ict_pkg;
  typedef enum logic [2:0] {
    OP_JREG  = 3'd0,
    OP_JTAB  = 3'd1,
    OP_JMEM  = 3'd2,
    OP_BAL   = 3'd3,
    OP_CALLR = 3'd4,
    OP_CALLM = 3'd5
  } ict_op_e;

  typedef struct packed {
    logic jump_now;  // resolves without memory
    logic use_tab;   // table-scaled target
    logic mem;       // target comes from memory
    logic link;      // writes fixed link register
    logic push;      // pushes return address
    logic illegal;   // unknown code
  } ict_ctl_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } ict_state_e;
endpackage

// File: rtl/ict_decode.sv
`timescale 1ns/1ps
module ict_decode
  import ict_pkg::*;
(
  input  logic [2:0] op_code,
  output ict_ctl_t   ctl
);
  always_comb begin
    ctl = '0;
    case (op_code)
      OP_JREG:  ctl.jump_now = 1'b1;
      OP_JTAB:  begin ctl.jump_now = 1'b1; ctl.use_tab = 1'b1; end
      OP_JMEM:  ctl.mem = 1'b1;
      OP_BAL:   begin ctl.jump_now = 1'b1; ctl.link = 1'b1; end
      OP_CALLR: begin ctl.jump_now = 1'b1; ctl.push = 1'b1; end
      OP_CALLM: begin ctl.mem = 1'b1; ctl.push = 1'b1; end
      default:  ctl.illegal = 1'b1;
    endcase
  end
endmodule

// File: rtl/ict_target.sv
`timescale 1ns/1ps
module ict_target #(
  parameter int XLEN        = 32,
  parameter int LIT_W       = 16,
  parameter int SKIP_W      = 6,
  parameter int ENTRY_SHIFT = 3
) (
  input  logic [XLEN-1:0]   cur_pc,
  input  logic [XLEN-1:0]   src_val,
  input  logic [LIT_W-1:0]  lit_val,
  input  logic [SKIP_W-1:0] skip_cnt,
  input  logic [XLEN-1:0]   sp_in,
  output logic [XLEN-1:0]   tab_pc,
  output logic [XLEN-1:0]   mem_addr,
  output logic [XLEN-1:0]   bal_ret,
  output logic [XLEN-1:0]   skip_ret,
  output logic [XLEN-1:0]   push_sp
);
  localparam int PC_BYTES  = 4;
  localparam int PC_SHIFT  = 2;

  function automatic logic [XLEN-1:0] zext_lit(input logic [LIT_W-1:0] v);
    return {{(XLEN-LIT_W){1'b0}}, v};
  endfunction

  function automatic logic [XLEN-1:0] f_table_pc(input logic [LIT_W-1:0] base,
                                                 input logic [XLEN-1:0] idx);
    return zext_lit(base) + (idx << ENTRY_SHIFT);
  endfunction

  function automatic logic [XLEN-1:0] f_load_addr(input logic [XLEN-1:0] reg_v,
                                                  input logic [LIT_W-1:0] off);
    return reg_v + zext_lit(off);
  endfunction

  function automatic logic [XLEN-1:0] f_skip_ret(input logic [XLEN-1:0] pc,
                                                 input logic [SKIP_W-1:0] n);
    return pc + ({{(XLEN-SKIP_W){1'b0}}, n} << PC_SHIFT);
  endfunction

  function automatic logic [XLEN-1:0] f_lower_sp(input logic [XLEN-1:0] sp);
    return sp - XLEN'(PC_BYTES);
  endfunction

  assign tab_pc   = f_table_pc(lit_val, src_val);
  assign mem_addr = f_load_addr(src_val, lit_val);
  assign bal_ret  = cur_pc + XLEN'(PC_BYTES);
  assign skip_ret = f_skip_ret(cur_pc, skip_cnt);
  assign push_sp  = f_lower_sp(sp_in);
endmodule

// File: rtl/ict_core.sv
`timescale 1ns/1ps
module ict_core
  import ict_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_valid,
  input  ict_ctl_t        ctl,
  input  logic [XLEN-1:0] src_val,
  input  logic [XLEN-1:0] tab_pc,
  input  logic [XLEN-1:0] mem_addr,
  input  logic [XLEN-1:0] bal_ret,
  input  logic [XLEN-1:0] skip_ret,
  input  logic [XLEN-1:0] sp_in,
  input  logic [XLEN-1:0] push_sp,
  input  logic [XLEN-1:0] rd_data,
  input  logic            rd_fault,
  output logic            busy,
  output logic            rd_req,
  output logic [XLEN-1:0] rd_addr,
  output logic            npc_valid,
  output logic [XLEN-1:0] npc,
  output logic            link_we,
  output logic [XLEN-1:0] link_val,
  output logic            wr_en,
  output logic [XLEN-1:0] wr_addr,
  output logic [XLEN-1:0] wr_data,
  output logic            sp_we,
  output logic [XLEN-1:0] sp_out,
  output logic            exc,
  output logic [XLEN-1:0] exc_addr,
  output logic            illegal
);
  localparam int PC_BYTES = 4;

  ict_state_e      state;
  logic            sv_push;
  logic [XLEN-1:0] sv_addr, sv_ret, sv_sp, sv_sp_new;

  // named events for the checks
  logic accept, resolve;
  assign accept  = op_valid && (state == ST_IDLE);
  assign resolve = (state == ST_WAIT);

  assign busy    = resolve;
  assign rd_req  = accept && ctl.mem;
  assign rd_addr = mem_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      sv_push   <= 1'b0;
      sv_addr   <= '0;
      sv_ret    <= '0;
      sv_sp     <= '0;
      sv_sp_new <= '0;
      npc_valid <= 1'b0;
      npc       <= '0;
      link_we   <= 1'b0;
      link_val  <= '0;
      wr_en     <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
      sp_we     <= 1'b0;
      sp_out    <= '0;
      exc       <= 1'b0;
      exc_addr  <= '0;
      illegal   <= 1'b0;
    end else begin
      npc_valid <= 1'b0;
      link_we   <= 1'b0;
      wr_en     <= 1'b0;
      sp_we     <= 1'b0;
      exc       <= 1'b0;
      illegal   <= 1'b0;
      if (resolve) begin
        state <= ST_IDLE;
        if (rd_fault) begin
          exc      <= 1'b1;
          exc_addr <= sv_addr;
        end else begin
          npc_valid <= 1'b1;
          npc       <= rd_data;
          if (sv_push) begin
            wr_en   <= 1'b1;
            wr_addr <= sv_sp;
            wr_data <= sv_ret;
            sp_we   <= 1'b1;
            sp_out  <= sv_sp_new;
          end
        end
      end else if (accept) begin
        if (ctl.illegal) begin
          illegal <= 1'b1;
        end else if (ctl.mem) begin
          state     <= ST_WAIT;
          sv_addr   <= mem_addr;
          sv_ret    <= skip_ret;
          sv_sp     <= sp_in;
          sv_sp_new <= push_sp;
          sv_push   <= ctl.push;
        end else begin
          npc_valid <= 1'b1;
          npc       <= ctl.use_tab ? tab_pc : src_val;
          if (ctl.link) begin
            link_we  <= 1'b1;
            link_val <= bal_ret;
          end
          if (ctl.push) begin
            wr_en   <= 1'b1;
            wr_addr <= sp_in;
            wr_data <= skip_ret;
            sp_we   <= 1'b1;
            sp_out  <= push_sp;
          end
        end
      end
    end
  end

  // R7: fault suppresses every committing strobe
  assert_fault_no_commit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    exc |-> (!npc_valid && !wr_en && !sp_we));

  // R5: stack write and pointer update travel together, pointer lowered one PC
  assert_push_paired_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (sp_we && (sp_out == wr_addr - XLEN'(PC_BYTES))));

  // R8: wait lasts exactly one cycle
  assert_wait_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);

  // R3: a read request always leads into the wait cycle
  assert_req_then_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> busy);

  // R8: no read request while waiting
  assert_no_req_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !rd_req);

  // R9: illegal code raises nothing else
  assert_illegal_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!npc_valid && !exc && !wr_en && !link_we && !sp_we));

  // R4: link write only with a PC and without a push
  assert_link_alone_R4: assert property (@(posedge clk) disable iff (!rst_n)
    link_we |-> (npc_valid && !wr_en));
endmodule

// File: rtl/ict_unit.sv
`timescale 1ns/1ps
module ict_unit
  import ict_pkg::*;
#(
  parameter int XLEN        = 32,
  parameter int LIT_W       = 16,
  parameter int SKIP_W      = 6,
  parameter int ENTRY_SHIFT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [2:0]        op_code,
  input  logic [XLEN-1:0]   cur_pc,
  input  logic [XLEN-1:0]   src_val,
  input  logic [LIT_W-1:0]  lit_val,
  input  logic [SKIP_W-1:0] skip_cnt,
  input  logic [XLEN-1:0]   sp_in,
  output logic              busy,
  output logic              rd_req,
  output logic [XLEN-1:0]   rd_addr,
  input  logic [XLEN-1:0]   rd_data,
  input  logic              rd_fault,
  output logic              npc_valid,
  output logic [XLEN-1:0]   npc,
  output logic              link_we,
  output logic [XLEN-1:0]   link_val,
  output logic              wr_en,
  output logic [XLEN-1:0]   wr_addr,
  output logic [XLEN-1:0]   wr_data,
  output logic              sp_we,
  output logic [XLEN-1:0]   sp_out,
  output logic              exc,
  output logic [XLEN-1:0]   exc_addr,
  output logic              illegal
);
  ict_ctl_t        ctl;
  logic [XLEN-1:0] tab_pc, mem_addr, bal_ret, skip_ret, push_sp;

  ict_decode u_dec (
    .op_code (op_code),
    .ctl     (ctl)
  );

  ict_target #(
    .XLEN(XLEN), .LIT_W(LIT_W), .SKIP_W(SKIP_W), .ENTRY_SHIFT(ENTRY_SHIFT)
  ) u_tgt (
    .cur_pc   (cur_pc),
    .src_val  (src_val),
    .lit_val  (lit_val),
    .skip_cnt (skip_cnt),
    .sp_in    (sp_in),
    .tab_pc   (tab_pc),
    .mem_addr (mem_addr),
    .bal_ret  (bal_ret),
    .skip_ret (skip_ret),
    .push_sp  (push_sp)
  );

  ict_core #(.XLEN(XLEN)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .ctl       (ctl),
    .src_val   (src_val),
    .tab_pc    (tab_pc),
    .mem_addr  (mem_addr),
    .bal_ret   (bal_ret),
    .skip_ret  (skip_ret),
    .sp_in     (sp_in),
    .push_sp   (push_sp),
    .rd_data   (rd_data),
    .rd_fault  (rd_fault),
    .busy      (busy),
    .rd_req    (rd_req),
    .rd_addr   (rd_addr),
    .npc_valid (npc_valid),
    .npc       (npc),
    .link_we   (link_we),
    .link_val  (link_val),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .sp_we     (sp_we),
    .sp_out    (sp_out),
    .exc       (exc),
    .exc_addr  (exc_addr),
    .illegal   (illegal)
  );

  // R9: decoded classes are mutually exclusive for any accepted code
  assert_class_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |-> $onehot({ctl.jump_now, ctl.mem, ctl.illegal}));

  // R10: strobes are quiet in the first cycle out of reset
  assert_quiet_after_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!npc_valid && !wr_en && !exc && !busy));
endmodule

// File: tb/ict_unit_test.sv
`timescale 1ns/1ps
module ict_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [2:0]  op_code = 3'd0;
  logic [31:0] cur_pc = '0, src_val = '0, sp_in = '0;
  logic [15:0] lit_val = '0;
  logic [5:0]  skip_cnt = '0;
  logic [31:0] rd_data = '0;
  logic        rd_fault = 1'b0;
  logic        busy, rd_req, npc_valid, link_we, wr_en, sp_we, exc, illegal;
  logic [31:0] rd_addr, npc, link_val, wr_addr, wr_data, sp_out, exc_addr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  ict_unit uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .cur_pc(cur_pc), .src_val(src_val), .lit_val(lit_val), .skip_cnt(skip_cnt),
    .sp_in(sp_in), .busy(busy), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_data(rd_data), .rd_fault(rd_fault), .npc_valid(npc_valid), .npc(npc),
    .link_we(link_we), .link_val(link_val), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .sp_we(sp_we), .sp_out(sp_out), .exc(exc),
    .exc_addr(exc_addr), .illegal(illegal)
  );

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return a ^ 32'hA5A5_0000;
  endfunction

  // memory model: answers one cycle after each request, faults in 0xF region
  always @(posedge clk) begin
    rd_data  <= rd_req ? mem_word(rd_addr) : 32'h0;
    rd_fault <= rd_req && (rd_addr[31:28] == 4'hF);
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] opc, input logic [31:0] pc, input logic [31:0] src,
                       input logic [15:0] lit, input logic [5:0] skp, input logic [31:0] sp);
    op_valid = 1'b1; op_code = opc; cur_pc = pc; src_val = src;
    lit_val = lit; skip_cnt = skp; sp_in = sp;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R10 npc_valid", {31'b0, npc_valid}, 32'd0);
    check("R10 busy", {31'b0, busy}, 32'd0);
    check("R10 strobes", {26'b0, wr_en, sp_we, link_we, exc, illegal, rd_req}, 32'd0);
  endtask

  task automatic t_jreg();
    @(negedge clk); issue(3'd0, 32'h100, 32'h1234_5678, 16'h0, 6'd0, 32'h8000);
    @(negedge clk); op_valid = 1'b0;
    check("R1 npc_valid", {31'b0, npc_valid}, 32'd1);
    check("R1 npc", npc, 32'h1234_5678);
    check("R1 no side strobes", {29'b0, link_we, wr_en, sp_we}, 32'd0);
    @(negedge clk);
    check("R1 pulse ends", {31'b0, npc_valid}, 32'd0);
  endtask

  task automatic t_jtab(input logic [31:0] idx, input logic [15:0] base);
    @(negedge clk); issue(3'd1, 32'h200, idx, base, 6'd0, 32'h8000);
    @(negedge clk); op_valid = 1'b0;
    check("R2 npc_valid", {31'b0, npc_valid}, 32'd1);
    check("R2 table target", npc, {16'b0, base} + idx * 32'd8);
  endtask

  task automatic t_jmem();
    logic [31:0] a;
    a = 32'h1000 + 32'h40;
    @(negedge clk); issue(3'd2, 32'h300, 32'h1000, 16'h40, 6'd0, 32'h8000);
    #1;
    check("R3 rd_req", {31'b0, rd_req}, 32'd1);
    check("R3 rd_addr", rd_addr, a);
    @(negedge clk);
    check("R8 busy in wait", {31'b0, busy}, 32'd1);
    check("R3 no pc yet", {31'b0, npc_valid}, 32'd0);
    issue(3'd0, 32'h304, 32'hDEAD_0000, 16'h0, 6'd0, 32'h8000); // ignored while busy
    #1;
    check("R8 no request while busy", {31'b0, rd_req}, 32'd0);
    @(negedge clk); op_valid = 1'b0;
    check("R3 npc_valid", {31'b0, npc_valid}, 32'd1);
    check("R3 loaded target", npc, mem_word(a));
    check("R8 busy cleared", {31'b0, busy}, 32'd0);
    @(negedge clk);
    check("R8 busy-time op ignored", {31'b0, npc_valid}, 32'd0);
  endtask

  task automatic t_bal();
    @(negedge clk); issue(3'd3, 32'h2000, 32'h3000, 16'h0, 6'd5, 32'h8000);
    @(negedge clk); op_valid = 1'b0;
    check("R4 npc", npc, 32'h3000);
    check("R4 link_we", {31'b0, link_we}, 32'd1);
    check("R4 link_val", link_val, 32'h2004);
    check("R4 no push", {30'b0, wr_en, sp_we}, 32'd0);
  endtask

  task automatic t_callr(input logic [5:0] skp);
    @(negedge clk); issue(3'd4, 32'h4000, 32'h6000, 16'h0, skp, 32'h8000);
    @(negedge clk); op_valid = 1'b0;
    check("R5 npc", npc, 32'h6000);
    check("R5 wr_en", {31'b0, wr_en}, 32'd1);
    check("R5 return addr", wr_data, 32'h4000 + {26'b0, skp} * 32'd4);
    check("R5 push addr", wr_addr, 32'h8000);
    check("R5 sp_out", sp_out, 32'h7FFC);
    check("R5 no link", {31'b0, link_we}, 32'd0);
  endtask

  task automatic t_callm();
    @(negedge clk); issue(3'd5, 32'h100, 32'h5000, 16'h8, 6'd2, 32'h9000);
    #1;
    check("R6 rd_addr", rd_addr, 32'h5008);
    @(negedge clk); issue(3'd0, 32'h0, 32'h0, 16'h0, 6'd0, 32'h0); op_valid = 1'b0;
    check("R6 no early push", {31'b0, wr_en}, 32'd0);
    @(negedge clk);
    check("R6 npc", npc, mem_word(32'h5008));
    check("R6 ret from accept-time pc", wr_data, 32'h108);
    check("R6 push addr", wr_addr, 32'h9000);
    check("R6 sp_out", sp_out, 32'h8FFC);
    check("R6 strobes", {29'b0, npc_valid, wr_en, sp_we}, 32'd7);
  endtask

  task automatic t_fault(input logic [2:0] opc);
    @(negedge clk); issue(opc, 32'h700, 32'hF000_0000, 16'h10, 6'd1, 32'hA000);
    @(negedge clk); op_valid = 1'b0;
    @(negedge clk);
    check("R7 exc", {31'b0, exc}, 32'd1);
    check("R7 exc_addr", exc_addr, 32'hF000_0010);
    check("R7 nothing committed", {29'b0, npc_valid, wr_en, sp_we}, 32'd0);
  endtask

  task automatic t_illegal(input logic [2:0] opc);
    @(negedge clk); issue(opc, 32'h800, 32'h900, 16'h4, 6'd1, 32'hB000);
    #1;
    check("R9 no read", {31'b0, rd_req}, 32'd0);
    @(negedge clk); op_valid = 1'b0;
    check("R9 illegal", {31'b0, illegal}, 32'd1);
    check("R9 quiet", {27'b0, npc_valid, wr_en, sp_we, link_we, exc}, 32'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_jreg();
    t_jtab(32'd5, 16'h0100);
    t_jtab(32'd0, 16'hFFF0);
    t_jmem();
    t_bal();
    t_callr(6'd3);
    t_callr(6'd1);
    t_callm();
    t_fault(3'd5);
    t_fault(3'd2);
    t_illegal(3'd6);
    t_illegal(3'd7);
    repeat (2) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end
endmodule